// File: doc/BRIEF.md
# Rotate and Wraparound Mask Unit

This block is a purely combinational rotate-and-mask datapath for an integer execution pipe. It takes a 64-bit operand, rotates it left by a 6-bit amount, and builds a run of contiguous ones between a begin index and an end index. It returns the rotated value, the mask, and the rotated value ANDed with the mask. Rotate-then-mask instructions are the main use, along with shift-with-mask forms where software chooses the mask edges.

Bit positions count from the most significant end: position 0 is the MSB, which has weight 2^63, and position 63 is the LSB. If the begin index is larger than the end index, the run of ones wraps from the LSB end back to the MSB end. A word-mode select picks one of two behaviours. With the select high, the low 32 bits of the operand are copied into both halves before rotation, and both mask indices are moved into the lower half of the word.

Top module: `rotmask_unit`

## Requirements
- R1: Position p means output bit weight 2^(63-p). When maskBegin <= maskEnd, maskOut is 1 exactly at positions maskBegin through maskEnd, both ends included, and 0 at every other position.
- R2: When the effective begin is greater than the effective end, maskOut is 1 at positions begin..63 and 0..end. The positions strictly between end and begin are 0.
- R3: When the effective begin equals the effective end, maskOut has exactly one bit set, at that position.
- R4: With wordMode=1, each index uses only its low 5 bits, and 32 is added to it. Begin 5, end 15 gives 0x0000_0000_07FF_0000. Begin 15, end 5 gives 0xFFFF_FFFF_FC01_FFFF.
- R5: With wordMode=0, rotOut is opIn rotated left by shAmt (0..63). For example, 0xDEADBEEF12345678 rotated by 10 gives 0xB6FBBC48D159E37A.
- R6: With wordMode=1, rotOut is the 64-bit value {opIn[31:0], opIn[31:0]} rotated left by shAmt modulo 32. Both halves of rotOut are therefore equal, and opIn[63:32] has no effect. For example, low word 0xDEADBEEF rotated by 10 gives 0xB6FBBF7A in each half.
- R7: With wordMode=0 and shAmt=0, rotOut equals opIn.
- R8: resultOut equals rotOut AND maskOut at all times, and the outputs follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opIn | input | 64 | Operand to rotate |
| shAmt | input | 6 | Left rotate amount |
| maskBegin | input | 6 | First mask position (0 = MSB) |
| maskEnd | input | 6 | Last mask position (0 = MSB) |
| wordMode | input | 1 | 1 = 32-bit replicate mode, 0 = 64-bit mode |
| rotOut | output | 64 | Rotated operand |
| maskOut | output | 64 | Generated mask |
| resultOut | output | 64 | rotOut AND maskOut |

## Verification
A table of known vectors fixes the bit ordering, and a wrong choice between MSB-first and LSB-first numbering mirrors every expected mask. The same table covers wrapped, non-wrapped and single-bit masks. In word mode it uses shift amounts above 31 and operands with a non-zero upper half, so it separates replication from zero extension and shows whether the upper half leaks through. An exhaustive sweep of all 4096 begin/end pairs in 64-bit mode is compared with a model that walks positions from begin to end. A sweep of all 64 shift amounts on an asymmetric operand is compared with a one-bit-at-a-time rotator, which catches errors in the rotate direction or in the amount wrap.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  localparam int WORD_W = 64;
  localparam int HALF_W = WORD_W / 2;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int HIDX_W = IDX_W - 1;

  typedef struct packed {
    logic             halfMode;
    logic [IDX_W-1:0] rotAmt;
    logic [IDX_W-1:0] mBegin;
    logic [IDX_W-1:0] mEnd;
    logic             wrapSel;
    logic             oneBit;
  } ctrlStrobes_t;
endpackage

// File: rtl/rmu_ctrl.sv
module rmu_ctrl
  import rotmask_pkg::*;
(
  input  logic [IDX_W-1:0] shAmt,
  input  logic [IDX_W-1:0] maskBegin,
  input  logic [IDX_W-1:0] maskEnd,
  input  logic             wordMode,
  output ctrlStrobes_t     ctrl
);
  localparam logic [IDX_W-1:0] HALF_OFS = IDX_W'(HALF_W);

  logic [IDX_W-1:0] effBegin;
  logic [IDX_W-1:0] effEnd;
  logic [IDX_W-1:0] effAmt;

  // word mode: indices move into the low half, amount wraps at 32
  always_comb begin
    if (wordMode) begin
      effBegin = HALF_OFS + {1'b0, maskBegin[HIDX_W-1:0]};
      effEnd   = HALF_OFS + {1'b0, maskEnd[HIDX_W-1:0]};
      effAmt   = {1'b0, shAmt[HIDX_W-1:0]};
    end else begin
      effBegin = maskBegin;
      effEnd   = maskEnd;
      effAmt   = shAmt;
    end
  end

  always_comb begin
    ctrl.halfMode = wordMode;
    ctrl.rotAmt   = effAmt;
    ctrl.mBegin   = effBegin;
    ctrl.mEnd     = effEnd;
    ctrl.wrapSel  = effBegin > effEnd;
    ctrl.oneBit   = effBegin == effEnd;
  end

  // R4
  always_comb begin
    if (wordMode) begin
      half_index_chk: assert (ctrl.mBegin[IDX_W-1] && ctrl.mEnd[IDX_W-1])
        else $error("word-mode index not in low half");
    end
  end
endmodule

// File: rtl/rmu_datapath.sv
module rmu_datapath
  import rotmask_pkg::*;
(
  input  logic [WORD_W-1:0] opIn,
  input  ctrlStrobes_t      ctrl,
  output logic [WORD_W-1:0] rotOut,
  output logic [WORD_W-1:0] maskOut,
  output logic [WORD_W-1:0] resultOut
);
  logic [WORD_W-1:0]   srcWord;
  logic [2*WORD_W-1:0] dblWord;

  assign srcWord = ctrl.halfMode ? {opIn[HALF_W-1:0], opIn[HALF_W-1:0]} : opIn;
  assign dblWord = {srcWord, srcWord} << ctrl.rotAmt;
  assign rotOut  = dblWord[2*WORD_W-1:WORD_W];

  // one cell per MSB-first position
  for (genvar p = 0; p < WORD_W; p++) begin : g_maskCell
    localparam logic [IDX_W-1:0] POS = IDX_W'(p);
    logic geBegin;
    logic leEnd;
    assign geBegin = POS >= ctrl.mBegin;
    assign leEnd   = POS <= ctrl.mEnd;
    assign maskOut[WORD_W-1-p] = ctrl.wrapSel ? (geBegin | leEnd) : (geBegin & leEnd);
  end

  assign resultOut = rotOut & maskOut;

  always_comb begin
    // R1
    if (!ctrl.wrapSel) begin
      mask_span_chk: assert ($countones(maskOut) == int'(ctrl.mEnd) - int'(ctrl.mBegin) + 1)
        else $error("plain mask width wrong");
    end
    // R2
    if (ctrl.wrapSel) begin
      mask_wrap_chk: assert (maskOut[WORD_W-1] && maskOut[0] &&
          $countones(maskOut) == WORD_W + 1 - int'(ctrl.mBegin) + int'(ctrl.mEnd))
        else $error("wrapped mask shape wrong");
    end
    // R3
    if (ctrl.oneBit) begin
      mask_single_chk: assert ($onehot(maskOut))
        else $error("single-bit mask not one-hot");
    end
    // R6
    if (ctrl.halfMode) begin
      half_rep_chk: assert (rotOut[WORD_W-1:HALF_W] == rotOut[HALF_W-1:0])
        else $error("word-mode halves differ");
    end
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
(
  input  logic [WORD_W-1:0] opIn,
  input  logic [IDX_W-1:0]  shAmt,
  input  logic [IDX_W-1:0]  maskBegin,
  input  logic [IDX_W-1:0]  maskEnd,
  input  logic              wordMode,
  output logic [WORD_W-1:0] rotOut,
  output logic [WORD_W-1:0] maskOut,
  output logic [WORD_W-1:0] resultOut
);
  ctrlStrobes_t ctrl;

  rmu_ctrl u_ctrl (
    .shAmt    (shAmt),
    .maskBegin(maskBegin),
    .maskEnd  (maskEnd),
    .wordMode (wordMode),
    .ctrl     (ctrl)
  );

  rmu_datapath u_dp (
    .opIn     (opIn),
    .ctrl     (ctrl),
    .rotOut   (rotOut),
    .maskOut  (maskOut),
    .resultOut(resultOut)
  );

  always_comb begin
    // R7
    if (!wordMode && shAmt == '0) begin
      zero_rot_chk: assert (rotOut == opIn) else $error("zero rotate altered operand");
    end
    // R8
    and_subset_chk: assert ((resultOut & ~rotOut) == '0 && (resultOut & ~maskOut) == '0)
      else $error("result has bits outside rot/mask");
  end
endmodule

// File: tb/tb_rotmask_unit.sv
module tb_rotmask_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] opIn;
  logic [5:0]  shAmt, maskBegin, maskEnd;
  logic        wordMode;
  logic [63:0] rotOut, maskOut, resultOut;

  rotmask_unit dut (
    .opIn(opIn), .shAmt(shAmt), .maskBegin(maskBegin), .maskEnd(maskEnd),
    .wordMode(wordMode), .rotOut(rotOut), .maskOut(maskOut), .resultOut(resultOut)
  );

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  localparam int NV = 11;
  localparam logic        V_MODE [NV] = '{0, 0, 1, 1, 1, 0, 0, 1, 0, 0, 1};
  localparam logic [5:0]  V_SH   [NV] = '{10, 35, 10, 42, 10, 0, 0, 0, 0, 0, 0};
  localparam logic [5:0]  V_B    [NV] = '{0, 37, 0, 5, 0, 47, 32, 15, 0, 32, 2};
  localparam logic [5:0]  V_E    [NV] = '{63, 63, 31, 15, 31, 37, 33, 5, 10, 32, 34};
  localparam logic [63:0] V_OP   [NV] = '{
    64'hDEADBEEF12345678, 64'hDEADBEEF12345678, 64'h00000000DEADBEEF,
    64'h00000000DEADBEEF, 64'hAAAAAAAADEADBEEF, 64'h0123456789ABCDEF,
    64'h0123456789ABCDEF, 64'hFFFFFFFF00000000, 64'h0123456789ABCDEF,
    64'h0123456789ABCDEF, 64'h123456789ABCDEF0};
  localparam logic [63:0] V_ROT  [NV] = '{
    64'hB6FBBC48D159E37A, 64'h91A2B3C6F56DF778, 64'hB6FBBF7AB6FBBF7A,
    64'hB6FBBF7AB6FBBF7A, 64'hB6FBBF7AB6FBBF7A, 64'h0123456789ABCDEF,
    64'h0123456789ABCDEF, 64'h0000000000000000, 64'h0123456789ABCDEF,
    64'h0123456789ABCDEF, 64'h9ABCDEF09ABCDEF0};
  localparam logic [63:0] V_MASK [NV] = '{
    64'hFFFFFFFFFFFFFFFF, 64'h0000000007FFFFFF, 64'h00000000FFFFFFFF,
    64'h0000000007FF0000, 64'h00000000FFFFFFFF, 64'hFFFFFFFFFC01FFFF,
    64'h00000000C0000000, 64'hFFFFFFFFFC01FFFF, 64'hFFE0000000000000,
    64'h0000000080000000, 64'h0000000020000000};

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic m, input logic [5:0] s, input logic [5:0] b,
                       input logic [5:0] e, input logic [63:0] op);
    @(negedge clk);
    wordMode = m; shAmt = s; maskBegin = b; maskEnd = e; opIn = op;
    #3;
  endtask

  // walk from begin toward end, wrapping, setting each visited position
  function automatic logic [63:0] walkMask(input int b, input int e);
    logic [63:0] m = '0;
    int pos = b;
    forever begin
      m[63 - pos] = 1'b1;
      if (pos == e) break;
      pos = (pos + 1) % 64;
    end
    return m;
  endfunction

  function automatic logic [63:0] stepRot(input logic [63:0] v, input int n);
    logic [63:0] r = v;
    for (int k = 0; k < n; k++) r = {r[62:0], r[63]};
    return r;
  endfunction

  initial begin
    wordMode = 0; shAmt = '0; maskBegin = '0; maskEnd = '0; opIn = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk); #3;
    // idle state: zero inputs -> zero rotate, single MSB mask (R3)
    check("R3 idle mask", maskOut, 64'h8000000000000000);
    check("R7 idle rot", rotOut, 64'h0);

    for (int i = 0; i < NV; i++) begin
      apply(V_MODE[i], V_SH[i], V_B[i], V_E[i], V_OP[i]);
      // R5 R6 R7 rotate value
      check($sformatf("R5/R6 rot row%0d", i), rotOut, V_ROT[i]);
      // R1 R2 R3 R4 mask value
      check($sformatf("R1/R2/R4 mask row%0d", i), maskOut, V_MASK[i]);
      // R8
      check($sformatf("R8 result row%0d", i), resultOut, V_ROT[i] & V_MASK[i]);
    end

    // R1 R2 R3 exhaustive 64-bit mask sweep
    for (int b = 0; b < 64; b++) begin
      for (int e = 0; e < 64; e++) begin
        apply(1'b0, 6'd0, 6'(b), 6'(e), 64'hFFFFFFFFFFFFFFFF);
        check($sformatf("R1/R2/R3 mask b%0d e%0d", b, e), maskOut, walkMask(b, e));
      end
    end

    // R5 R7 every amount in 64-bit mode
    for (int s = 0; s < 64; s++) begin
      apply(1'b0, 6'(s), 6'd0, 6'd63, 64'hF0E1D2C3B4A59687);
      check($sformatf("R5 rot s%0d", s), rotOut, stepRot(64'hF0E1D2C3B4A59687, s));
    end

    // R6 every amount in word mode, upper half junk
    for (int s = 0; s < 64; s++) begin
      apply(1'b1, 6'(s), 6'd0, 6'd31, 64'h5555AAAA13579BDF);
      check($sformatf("R6 rot s%0d", s), rotOut,
            stepRot({32'h13579BDF, 32'h13579BDF}, s % 32));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule